// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block lays a 32x32 two-colour cursor over a stream of pixels on their way to the display. Software programs it through a 32-bit register port. One register holds the cursor position, with both coordinates packed into one word. Two tables of 32 words, one word per cursor row, hold a mask plane and a colour-bit plane. A further general-purpose register stores whatever is written to it.

Each incoming pixel carries its screen coordinates and a base colour. If the pixel falls inside the visible cursor window and the mask bit for that location is set, the base colour is replaced by one of two overlay colours, chosen by the colour bit. All other pixels pass through unchanged. The stream uses a valid/ready handshake and has one register stage.

Every write that moves the cursor or changes its shape produces an invalidate strobe. The strobe names the span of screen lines that must be redrawn. A position change reports two spans: the lines under the old position and the lines under the new one. Screen width and height are inputs. The two overlay colours also come from outside the block.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, both cursor coordinates are 0xF000. No pixel is altered, no invalidate is raised, out_valid is 0, in_ready is 1, and a read of offset 0x818 returns 0x02000000.
- R2: A write to offset 0x8FC sets the cursor column from data bits 31:16 and the cursor line from data bits 15:0.
- R3: A write to offset 0x900+4r stores mask row r, and a write to offset 0x980+4r stores colour-bit row r, for r in 0..31. A row rewritten with a zero mask stops altering its pixels.
- R4: Within a stored row, bit 31 applies to screen column cursx and bit 31-k applies to column cursx+k.
- R5: Where the mask bit is 1, the output is ovl_col1 if the colour bit is 1 and ovl_col0 if it is 0. Where the mask bit is 0, the base colour passes through.
- R6: The overlay applies only when cursy <= y < cursy+32, cursx <= x < cursx+32, x < scr_width and cursx < scr_width. When cursx >= scr_width, nothing is overlaid.
- R7: Offset 0x818 stores written data and reads back as that value OR 0x02000000. Every other offset reads 0. Reads are combinational on reg_addr.
- R8: In the cycle after a position, mask or bit write, inv_cur_valid pulses with inv_cur_lo = cursy (the new value for a position write) and inv_cur_hi = min(scr_height, cursy+32), exclusive. There is no pulse when cursy >= scr_height. A write to the general-purpose register raises no pulse.
- R9: A position write also pulses inv_old_valid in that same cycle, with the range computed from the cursor line held before the write and the same suppression rule.
- R10: in_ready = !out_valid || out_ready. An accepted pixel appears on the output on the next clock and is held stable while out_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| scr_width | input | 16 | Visible screen width in pixels |
| scr_height | input | 16 | Visible screen height in lines |
| ovl_col0 | input | PIX_W | Colour used where mask=1 and bit=0 |
| ovl_col1 | input | PIX_W | Colour used where mask=1 and bit=1 |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_x | input | 16 | Input pixel column |
| in_y | input | 16 | Input pixel line |
| in_pix | input | PIX_W | Base colour |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Sink accepts output pixel |
| out_pix | output | PIX_W | Merged colour |
| inv_cur_valid | output | 1 | Invalidate for the current position |
| inv_cur_lo | output | 16 | First line to redraw |
| inv_cur_hi | output | 16 | Line after the last one to redraw |
| inv_old_valid | output | 1 | Invalidate for the previous position |
| inv_old_lo | output | 16 | First line of the previous range |
| inv_old_hi | output | 16 | End of the previous range, exclusive |

## Verification
The bench places the cursor against the right screen edge and beyond it. A design that clips wrongly would paint past scr_width or would draw a cursor whose column is off screen. It scans columns on both sides of the window and lines at the first and last cursor row, which catches an off-by-one window or a row that is reversed bit for bit. It moves the cursor near the bottom edge and then onto it. This checks that the invalidate range is clamped to the screen height and suppressed off screen, and that the old-position span reports the line held before the write rather than the new one. A stalled sink checks that a pixel is neither dropped nor overwritten while out_ready is low.

// File: rtl/cursor_overlay_pkg.sv
package cursor_overlay_pkg;
    localparam int CUR_DIM  = 32;
    localparam int ROW_AW   = $clog2(CUR_DIM);
    localparam int TBL_SH   = ROW_AW + 2;
    localparam int REG_AW   = 12;
    localparam int WORD_W   = 32;
    localparam int CRD_W    = 16;

    localparam logic [REG_AW-1:0] OFF_POS  = 12'h8FC;
    localparam logic [REG_AW-1:0] OFF_MISC = 12'h818;
    localparam logic [REG_AW-1:0] OFF_MASK = 12'h900;
    localparam logic [REG_AW-1:0] OFF_BITS = 12'h980;
    localparam logic [WORD_W-1:0] MISC_FORCE = 32'h0200_0000;
    localparam logic [CRD_W-1:0]  PARK_POS   = 16'hF000;

    typedef logic [CRD_W-1:0]   crd_t;
    typedef logic [CUR_DIM-1:0] row_t;

    // exclusive end of the line window touched by a cursor at line y
    function automatic crd_t win_end(crd_t y, crd_t h);
        logic [CRD_W:0] sum;
        sum = {1'b0, y} + (CRD_W+1)'(CUR_DIM);
        return (sum > {1'b0, h}) ? h : sum[CRD_W-1:0];
    endfunction
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
    import cursor_overlay_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [REG_AW-1:0]      reg_addr,
    input  logic [WORD_W-1:0]      reg_wdata,
    output logic [WORD_W-1:0]      reg_rdata,
    input  crd_t                   scr_height,
    output crd_t                   cur_x,
    output crd_t                   cur_y,
    output row_t [CUR_DIM-1:0]     mask_rows,
    output row_t [CUR_DIM-1:0]     bit_rows,
    output logic                   inv_cur_valid,
    output crd_t                   inv_cur_lo,
    output crd_t                   inv_cur_hi,
    output logic                   inv_old_valid,
    output crd_t                   inv_old_lo,
    output crd_t                   inv_old_hi
);
    typedef struct packed {
        crd_t                 x;
        crd_t                 y;
        logic [WORD_W-1:0]    misc;
        row_t [CUR_DIM-1:0]   mask;
        row_t [CUR_DIM-1:0]   bits;
        logic                 cv;
        crd_t                 clo;
        crd_t                 chi;
        logic                 ov;
        crd_t                 olo;
        crd_t                 ohi;
    } reg_state_t;

    reg_state_t s_d, s_q;
    logic              hit_mask, hit_bits, touch;
    logic [ROW_AW-1:0] row;
    crd_t              new_y;

    assign hit_mask = reg_addr[REG_AW-1:TBL_SH] == OFF_MASK[REG_AW-1:TBL_SH];
    assign hit_bits = reg_addr[REG_AW-1:TBL_SH] == OFF_BITS[REG_AW-1:TBL_SH];
    assign row      = reg_addr[TBL_SH-1:2];

    always_comb begin
        s_d    = s_q;
        s_d.cv = 1'b0;
        s_d.ov = 1'b0;
        touch  = 1'b0;
        new_y  = s_q.y;
        if (reg_wr) begin
            if (reg_addr == OFF_POS) begin
                s_d.x  = reg_wdata[31:16];
                s_d.y  = reg_wdata[15:0];
                new_y  = reg_wdata[15:0];
                touch  = 1'b1;
                s_d.ov  = s_q.y < scr_height;
                s_d.olo = s_q.y;
                s_d.ohi = win_end(s_q.y, scr_height);
            end else if (hit_mask) begin
                s_d.mask[row] = reg_wdata;
                touch = 1'b1;
            end else if (hit_bits) begin
                s_d.bits[row] = reg_wdata;
                touch = 1'b1;
            end else if (reg_addr == OFF_MISC) begin
                s_d.misc = reg_wdata;
            end
        end
        if (touch) begin
            s_d.cv  = new_y < scr_height;
            s_d.clo = new_y;
            s_d.chi = win_end(new_y, scr_height);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q   <= '0;
            s_q.x <= PARK_POS;
            s_q.y <= PARK_POS;
        end else begin
            s_q <= s_d;
        end
    end

    assign reg_rdata     = (reg_addr == OFF_MISC) ? (s_q.misc | MISC_FORCE) : '0;
    assign cur_x         = s_q.x;
    assign cur_y         = s_q.y;
    assign mask_rows     = s_q.mask;
    assign bit_rows      = s_q.bits;
    assign inv_cur_valid = s_q.cv;
    assign inv_cur_lo    = s_q.clo;
    assign inv_cur_hi    = s_q.chi;
    assign inv_old_valid = s_q.ov;
    assign inv_old_lo    = s_q.olo;
    assign inv_old_hi    = s_q.ohi;
endmodule

// File: rtl/cursor_blend.sv
module cursor_blend
    import cursor_overlay_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  crd_t               cur_x,
    input  crd_t               cur_y,
    input  row_t [CUR_DIM-1:0] mask_rows,
    input  row_t [CUR_DIM-1:0] bit_rows,
    input  crd_t               scr_width,
    input  logic [PIX_W-1:0]   ovl_col0,
    input  logic [PIX_W-1:0]   ovl_col1,
    input  logic               in_valid,
    output logic               in_ready,
    input  crd_t               in_x,
    input  crd_t               in_y,
    input  logic [PIX_W-1:0]   in_pix,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [PIX_W-1:0]   out_pix
);
    typedef struct packed {
        logic             v;
        logic [PIX_W-1:0] pix;
    } pipe_t;

    pipe_t p_d, p_q;
    logic [CRD_W:0]    dx, dy;
    logic              vhit, hhit;
    logic [ROW_AW-1:0] r_idx, b_idx;
    logic [PIX_W-1:0]  merged;

    always_comb begin
        dy     = {1'b0, in_y} - {1'b0, cur_y};
        dx     = {1'b0, in_x} - {1'b0, cur_x};
        vhit   = (in_y >= cur_y) && (dy < (CRD_W+1)'(CUR_DIM));
        hhit   = (cur_x < scr_width) && (in_x >= cur_x) &&
                 (dx < (CRD_W+1)'(CUR_DIM)) && (in_x < scr_width);
        r_idx  = dy[ROW_AW-1:0];
        b_idx  = ROW_AW'(CUR_DIM-1) - dx[ROW_AW-1:0];
        merged = in_pix;
        if (vhit && hhit && mask_rows[r_idx][b_idx]) begin
            merged = bit_rows[r_idx][b_idx] ? ovl_col1 : ovl_col0;
        end
        in_ready = !p_q.v || out_ready;
        p_d = p_q;
        if (out_ready) p_d.v = 1'b0;
        if (in_valid && in_ready) begin
            p_d.v   = 1'b1;
            p_d.pix = merged;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign out_valid = p_q.v;
    assign out_pix   = p_q.pix;
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_overlay_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [11:0]      reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [15:0]      scr_width,
    input  logic [15:0]      scr_height,
    input  logic [PIX_W-1:0] ovl_col0,
    input  logic [PIX_W-1:0] ovl_col1,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [15:0]      in_x,
    input  logic [15:0]      in_y,
    input  logic [PIX_W-1:0] in_pix,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PIX_W-1:0] out_pix,
    output logic             inv_cur_valid,
    output logic [15:0]      inv_cur_lo,
    output logic [15:0]      inv_cur_hi,
    output logic             inv_old_valid,
    output logic [15:0]      inv_old_lo,
    output logic [15:0]      inv_old_hi
);
    crd_t               cx, cy;
    row_t [CUR_DIM-1:0] mrows, brows;

    cursor_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .scr_height(scr_height),
        .cur_x(cx), .cur_y(cy), .mask_rows(mrows), .bit_rows(brows),
        .inv_cur_valid(inv_cur_valid), .inv_cur_lo(inv_cur_lo), .inv_cur_hi(inv_cur_hi),
        .inv_old_valid(inv_old_valid), .inv_old_lo(inv_old_lo), .inv_old_hi(inv_old_hi)
    );

    cursor_blend #(.PIX_W(PIX_W)) u_blend (
        .clk(clk), .rst_n(rst_n),
        .cur_x(cx), .cur_y(cy), .mask_rows(mrows), .bit_rows(brows),
        .scr_width(scr_width), .ovl_col0(ovl_col0), .ovl_col1(ovl_col1),
        .in_valid(in_valid), .in_ready(in_ready), .in_x(in_x), .in_y(in_y),
        .in_pix(in_pix), .out_valid(out_valid), .out_ready(out_ready),
        .out_pix(out_pix)
    );
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
    parameter int PIX_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [11:0]      reg_addr,
    input logic [31:0]      reg_rdata,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [PIX_W-1:0] out_pix,
    input logic             inv_cur_valid,
    input logic [15:0]      inv_cur_lo,
    input logic [15:0]      inv_cur_hi,
    input logic             inv_old_valid
);
    // R10
    ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);
    // R10
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pix));
    // R10
    accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);
    // R9
    old_inv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_old_valid |-> $past(reg_wr) && ($past(reg_addr) == 12'h8FC));
    // R8
    cur_inv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_cur_valid |-> $past(reg_wr));
    // R8
    cur_inv_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_cur_valid |-> (inv_cur_lo < inv_cur_hi) && ((inv_cur_hi - inv_cur_lo) <= 16'd32));
    // R7
    rd_other_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != 12'h818) |-> (reg_rdata == 32'h0));
    // R7
    misc_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 12'h818) |-> reg_rdata[25]);
endmodule

bind cursor_overlay cursor_overlay_chk #(.PIX_W(PIX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
    .inv_cur_valid(inv_cur_valid), .inv_cur_lo(inv_cur_lo), .inv_cur_hi(inv_cur_hi),
    .inv_old_valid(inv_old_valid)
);

// File: tb/tb_cursor_overlay.sv
`timescale 1ns/1ps
module tb_cursor_overlay;
    localparam int PW  = 24;
    localparam int WID = 640;
    localparam int HGT = 480;
    localparam logic [PW-1:0] C0 = 24'hC0C0C0;
    localparam logic [PW-1:0] C1 = 24'h123456;

    logic clk = 0, rst_n = 0;
    logic reg_wr = 0;
    logic [11:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic in_valid = 0, in_ready, out_valid, out_ready = 1;
    logic [15:0] in_x = 0, in_y = 0;
    logic [PW-1:0] in_pix = 0, out_pix;
    logic inv_cur_valid, inv_old_valid;
    logic [15:0] inv_cur_lo, inv_cur_hi, inv_old_lo, inv_old_hi;

    always #4 clk = ~clk;

    cursor_overlay #(.PIX_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .scr_width(16'(WID)), .scr_height(16'(HGT)),
        .ovl_col0(C0), .ovl_col1(C1),
        .in_valid(in_valid), .in_ready(in_ready), .in_x(in_x), .in_y(in_y),
        .in_pix(in_pix), .out_valid(out_valid), .out_ready(out_ready),
        .out_pix(out_pix),
        .inv_cur_valid(inv_cur_valid), .inv_cur_lo(inv_cur_lo), .inv_cur_hi(inv_cur_hi),
        .inv_old_valid(inv_old_valid), .inv_old_lo(inv_old_lo), .inv_old_hi(inv_old_hi)
    );

    int total = 0, bad = 0;
    string ph = "R1";
    int px = 'hF000, py = 'hF000;
    logic [31:0] m_mask [32];
    logic [31:0] m_bits [32];
    logic [PW-1:0] expq [$];

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] ref_pix(int x, int y, logic [PW-1:0] base);
        int c, r;
        if (y >= py && y < py + 32 && px < WID && x >= px && x < px + 32 && x < WID) begin
            c = x - px;
            r = y - py;
            if (m_mask[r][31-c]) return m_bits[r][31-c] ? C1 : C0;
        end
        return base;
    endfunction

    // reference comparison on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready) begin
                if (expq.size() == 0) chk(1'b0, "R10", 32'(out_pix), 32'hX);
                else begin
                    logic [PW-1:0] e;
                    e = expq.pop_front();
                    chk(out_pix === e, ph, 32'(out_pix), 32'(e));
                end
            end
            if (in_valid && in_ready) expq.push_back(ref_pix(int'(in_x), int'(in_y), in_pix));
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string req);
        logic ecv, eov;
        int elo, ehi, olo, ohi, ny;
        logic touch;
        touch = 1'b0; eov = 1'b0; ny = py; olo = 0; ohi = 0;
        if (a == 12'h8FC) begin
            eov = py < HGT; olo = py; ohi = (py + 32 < HGT) ? py + 32 : HGT;
            px = int'(d[31:16]); py = int'(d[15:0]); ny = py; touch = 1'b1;
        end else if (a >= 12'h900 && a < 12'h980) begin
            m_mask[(a - 12'h900) >> 2] = d; touch = 1'b1;
        end else if (a >= 12'h980 && a < 12'hA00) begin
            m_bits[(a - 12'h980) >> 2] = d; touch = 1'b1;
        end
        ecv = touch && ny < HGT;
        elo = ny; ehi = (ny + 32 < HGT) ? ny + 32 : HGT;
        @(posedge clk); #1;
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 0; reg_addr = 0;
        chk(inv_cur_valid == ecv, req, 32'(inv_cur_valid), 32'(ecv));
        if (ecv) chk(inv_cur_lo == 16'(elo) && inv_cur_hi == 16'(ehi), req,
                     {inv_cur_lo, inv_cur_hi}, {16'(elo), 16'(ehi)});
        chk(inv_old_valid == eov, "R9", 32'(inv_old_valid), 32'(eov));
        if (eov) chk(inv_old_lo == 16'(olo) && inv_old_hi == 16'(ohi), "R9",
                     {inv_old_lo, inv_old_hi}, {16'(olo), 16'(ohi)});
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string req);
        @(posedge clk); #1;
        reg_addr = a;
        #1;
        chk(reg_rdata === e, req, reg_rdata, e);
        reg_addr = 0;
    endtask

    task automatic scan(input int y, input int x0, input int x1, input string req);
        @(posedge clk); #1;
        ph = req;
        for (int x = x0; x <= x1; x++) begin
            in_valid = 1; in_x = 16'(x); in_y = 16'(y);
            in_pix = {8'h5A, 8'(y), 8'(x)};
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            @(posedge clk); #1;
        end
        in_valid = 0;
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=running exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin m_mask[i] = 0; m_bits[i] = 0; end
        repeat (5) @(posedge clk);
        #1 rst_n = 1;
        #1;
        // R1 reset state
        chk(out_valid == 0, "R1", 32'(out_valid), 0);
        chk(in_ready == 1, "R1", 32'(in_ready), 1);
        chk(!inv_cur_valid && !inv_old_valid, "R1", {inv_cur_valid, inv_old_valid}, 0);
        rd(12'h818, 32'h0200_0000, "R1");
        scan(5, 0, 3, "R1");

        // R3 rows loaded while parked: R8 suppression (cursy >= height)
        wr(12'h900, 32'hFFFF_FFFF, "R3");
        wr(12'h980, 32'hAAAA_AAAA, "R3");
        wr(12'h904, 32'h8000_0001, "R3");
        wr(12'h984, 32'h8000_0000, "R3");
        wr(12'h940, 32'h0F0F_0F0F, "R3");
        wr(12'h9C0, 32'hFFFF_FFFF, "R3");
        wr(12'h97C, 32'h0000_FFFF, "R8");
        wr(12'h9FC, 32'h0000_F0F0, "R8");

        // R2 position
        wr(12'h8FC, {16'd100, 16'd50}, "R2");
        scan(49, 98, 134, "R6");
        scan(50, 98, 134, "R4");
        scan(51, 98, 134, "R5");
        scan(66, 98, 134, "R5");
        scan(81, 98, 134, "R6");
        scan(82, 98, 134, "R6");

        // right and bottom edges
        wr(12'h8FC, {16'd620, 16'd460}, "R8");
        scan(460, 618, 645, "R6");
        scan(476, 618, 645, "R6");
        wr(12'h8FC, {16'd640, 16'd10}, "R2");
        scan(10, 636, 645, "R6");
        wr(12'h8FC, {16'd0, 16'd480}, "R8");
        wr(12'h8FC, {16'd0, 16'd0}, "R2");
        scan(0, 0, 33, "R4");
        scan(31, 0, 33, "R5");
        wr(12'h900, 32'h0, "R3");
        scan(0, 0, 33, "R3");

        // R7 general register and other offsets
        wr(12'h818, 32'h0000_0055, "R7");
        rd(12'h818, 32'h0200_0055, "R7");
        rd(12'h900, 32'h0, "R7");
        rd(12'h8FC, 32'h0, "R7");

        // R10 stall
        @(posedge clk); #1;
        ph = "R10";
        out_ready = 0;
        in_valid = 1; in_x = 1; in_y = 1; in_pix = 24'h777777;
        @(posedge clk); #1;
        in_valid = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(out_valid == 1 && in_ready == 0, "R10", {out_valid, in_ready}, 2);
            chk(expq.size() == 1 && out_pix === expq[0], "R10", 32'(out_pix),
                32'(expq.size() > 0 ? expq[0] : '0));
        end
        @(posedge clk); #1;
        out_ready = 1;
        repeat (3) @(posedge clk);
        #1;
        chk(expq.size() == 0, "R10", expq.size(), 0);
        chk(out_valid == 0, "R10", 32'(out_valid), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule